// File: doc/BRIEF.md
# I2C Single-Master Byte Controller

This block is the only master on a two-wire I2C bus. It divides the system clock down to a bus bit rate, 100 kHz or 400 kHz, selected by a mode input. Pulling the active-low enable low starts a transfer. The controller sends a START condition, then the 7-bit target address with a direction bit, and then moves 8-bit data bytes one after another. After every byte it handles the acknowledge slot. SCL is a push-pull output that only the master drives. SDA is open-drain and is modelled as a pull-down enable plus a sampled input.

The user decides how long a transfer lasts with the enable input. While the enable is held low, another byte follows. Once it is released, the controller finishes with a STOP condition. On writes, the next byte is taken from the write-data input when it is loaded. On reads, each received byte appears on the read-data output together with a one-cycle strobe.

If a target does not acknowledge its address or a written byte, the controller stops moving. It parks with SCL low and SDA released, and raises its error flag. It stays there until the user pulses the stop request, which produces a STOP condition and returns the controller to idle.

Top module: `i2c_byte_master`

## Requirements
- R1: Out of reset and whenever busy is 0, SCL is high, SDA is released (sda_oe_o = 0), and error is 0.
- R2: While idle, a high ce_n leaves the controller idle: busy stays 0 and no START appears.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. At all other times SDA changes only while SCL is low. Each completed transfer shows exactly one START and one STOP.
- R4: Each SCL bit period lasts DIV_FAST system clocks when fast_mode = 1 and DIV_STD clocks when fast_mode = 0. SCL is high for half of each period. fast_mode is sampled when the transfer starts.
- R5: The first byte after START is the 7 address bits, MSB first, followed by the direction bit (1 = read, 0 = write). rw is sampled when the transfer starts.
- R6: On a write, data bytes go out MSB first. wr_data is loaded at the start of each byte. The controller sends another byte if ce_n is low at the end of the acknowledge slot; otherwise it sends STOP.
- R7: On a read, the byte received MSB first appears on rd_data in the same cycle as byte_done. The master drives ACK (SDA low) if ce_n is low at the end of the first quarter of the acknowledge slot. Otherwise it drives NACK and then STOP.
- R8: If the acknowledge bit is sampled high after the address or after a written byte, the controller raises error with busy held at 1, SCL low and SDA released, and it sends no STOP.
- R9: stop_req while error is set produces a STOP condition. Error then clears, busy falls, and a new transfer can follow.
- R10: byte_done is a single-cycle pulse at the end of the eighth bit of each data byte, with one pulse per data byte.
- R11: stop_req has no effect while idle or during a transfer that has no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low enable: starts a transfer and asks for more bytes |
| fast_mode | input | 1 | 1 selects the 400 kHz bit rate, 0 selects 100 kHz |
| slave_addr | input | AW | Target address |
| rw | input | 1 | Direction: 1 read, 0 write |
| wr_data | input | DW | Byte to transmit |
| stop_req | input | 1 | Leave the error state with a STOP |
| sda_i | input | 1 | Sampled SDA line level |
| scl_o | output | 1 | Bus clock (push-pull) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_data | output | DW | Last received byte |
| byte_done | output | 1 | Data byte finished strobe |
| busy | output | 1 | Transfer in progress |
| error | output | 1 | Parked after a missing acknowledge |

## Verification
The bench builds the controller with DIV_STD = 40 and DIV_FAST = 16, which gives quarter phases of 10 and 4 clocks. At these divider values, multi-byte transfers in both bit-rate modes, both abort paths and the recovery by stop request all fit in a short run. The default width parameters are kept. A bus-level target model acknowledges one fixed address and can refuse a chosen written byte. A bus monitor measures every SCL period and high time and counts START and STOP events against the values the requirements give.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_STOP,
    ST_ERR
  } i2cm_state_t;

  // SCL level for a state and quarter phase: high in the second half of a bit.
  function automatic logic scl_level(i2cm_state_t s, logic [1:0] ph);
    case (s)
      ST_IDLE, ST_START: return 1'b1;
      ST_ERR:            return 1'b0;
      default:           return ph[1];
    endcase
  endfunction

endpackage

// File: rtl/i2cm_phase_gen.sv
module i2cm_phase_gen #(
  parameter int DIV_STD  = 1000,
  parameter int DIV_FAST = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       fast,
  output logic [1:0] phase,
  output logic       step
);
  localparam int Q_STD  = DIV_STD / 4;
  localparam int Q_FAST = DIV_FAST / 4;
  localparam int Q_MAX  = (Q_STD > Q_FAST) ? Q_STD : Q_FAST;
  localparam int CW     = $clog2(Q_MAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = fast ? CW'(Q_FAST - 1) : CW'(Q_STD - 1);
  assign step = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      phase <= 2'd0;
    end else if (step) begin
      cnt   <= '0;
      phase <= phase + 2'd1;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // Quarter counter never passes the limit of the selected rate.
  assert_quarter_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt <= lim);

endmodule

// File: rtl/i2cm_shreg.sv
module i2cm_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {q[W-2:0], sin};
  end

  // MSB-first order: after a shift the next lower bit becomes the MSB.
  assert_msb_first_R5: assert property (@(posedge clk) disable iff (rst)
    (shift && !load) |=> q[W-1] == $past(q[W-2]));

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int DIV_STD  = 1000,
  parameter int DIV_FAST = 250,
  parameter int AW       = 7,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          fast_mode,
  input  logic [AW-1:0] slave_addr,
  input  logic          rw,
  input  logic [DW-1:0] wr_data,
  input  logic          stop_req,
  input  logic          sda_i,
  output logic          scl_o,
  output logic          sda_oe_o,
  output logic [DW-1:0] rd_data,
  output logic          byte_done,
  output logic          busy,
  output logic          error
);
  localparam int SW = (AW + 1 > DW) ? AW + 1 : DW;
  localparam int BW = $clog2(SW);

  i2cm_state_t   st_q;
  logic [BW-1:0] bit_q;
  logic [AW-1:0] addr_q;
  logic          rw_q, fast_q, ack_bad_q, more_q;
  logic          run, step;
  logic [1:0]    phase;
  logic          s0, s2, s3;
  logic          sh_load, sh_shift, sh_sin;
  logic [SW-1:0] sh_din, sh_q;
  logic          sda_low_d;

  assign run = (st_q != ST_IDLE) && (st_q != ST_ERR);
  assign s0  = step && (phase == 2'd0);
  assign s2  = step && (phase == 2'd2);
  assign s3  = step && (phase == 2'd3);

  i2cm_phase_gen #(.DIV_STD(DIV_STD), .DIV_FAST(DIV_FAST)) u_phase (
    .clk(clk), .rst(rst), .run(run), .fast(fast_q), .phase(phase), .step(step)
  );

  i2cm_shreg #(.W(SW)) u_shreg (
    .clk(clk), .rst(rst), .load(sh_load), .din(sh_din),
    .shift(sh_shift), .sin(sh_sin), .q(sh_q)
  );

  // Shift register control
  always_comb begin
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_sin   = 1'b0;
    sh_din   = SW'(wr_data) << (SW - DW);
    case (st_q)
      ST_START: if (s3) begin
        sh_load = 1'b1;
        sh_din  = SW'({addr_q, rw_q}) << (SW - AW - 1);
      end
      ST_ADDR: if (s3 && bit_q != BW'(AW)) sh_shift = 1'b1;
      ST_WR:   if (s3 && bit_q != BW'(DW - 1)) sh_shift = 1'b1;
      ST_ADDR_ACK: if (s3 && !ack_bad_q && !rw_q) sh_load = 1'b1;
      ST_WR_ACK:   if (s3 && !ack_bad_q && !ce_n) sh_load = 1'b1;
      ST_RD: if (s2) begin
        sh_shift = 1'b1;
        sh_sin   = sda_i;
      end
      default: ;
    endcase
  end

  // SDA pull-down for the current state; quarter 0 of a bit holds the line
  // so that SDA never moves in the cycle SCL falls.
  always_comb begin
    case (st_q)
      ST_IDLE:  sda_low_d = 1'b0;
      ST_START: sda_low_d = phase[1];
      ST_ADDR, ST_WR:
        sda_low_d = (phase == 2'd0) ? sda_oe_o : !sh_q[SW-1];
      ST_ADDR_ACK, ST_WR_ACK, ST_RD:
        sda_low_d = (phase == 2'd0) ? sda_oe_o : 1'b0;
      ST_RD_ACK:
        sda_low_d = (phase == 2'd0) ? sda_oe_o : more_q;
      ST_STOP:
        sda_low_d = (phase == 2'd0) ? sda_oe_o : (phase != 2'd3);
      default:  sda_low_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      addr_q    <= '0;
      rw_q      <= 1'b0;
      fast_q    <= 1'b0;
      ack_bad_q <= 1'b0;
      more_q    <= 1'b0;
      rd_data   <= '0;
      byte_done <= 1'b0;
      scl_o     <= 1'b1;
      sda_oe_o  <= 1'b0;
      busy      <= 1'b0;
      error     <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      case (st_q)
        ST_IDLE: if (!ce_n) begin
          addr_q <= slave_addr;
          rw_q   <= rw;
          fast_q <= fast_mode;
          st_q   <= ST_START;
        end
        ST_START: if (s3) begin
          st_q  <= ST_ADDR;
          bit_q <= '0;
        end
        ST_ADDR: if (s3) begin
          if (bit_q == BW'(AW)) st_q <= ST_ADDR_ACK;
          else                  bit_q <= bit_q + BW'(1);
        end
        ST_ADDR_ACK: begin
          if (s2) ack_bad_q <= sda_i;
          if (s3) begin
            bit_q <= '0;
            if (ack_bad_q) st_q <= ST_ERR;
            else if (rw_q) st_q <= ST_RD;
            else           st_q <= ST_WR;
          end
        end
        ST_WR: if (s3) begin
          if (bit_q == BW'(DW - 1)) begin
            byte_done <= 1'b1;
            st_q      <= ST_WR_ACK;
          end else begin
            bit_q <= bit_q + BW'(1);
          end
        end
        ST_WR_ACK: begin
          if (s2) ack_bad_q <= sda_i;
          if (s3) begin
            bit_q <= '0;
            if (ack_bad_q) st_q <= ST_ERR;
            else if (!ce_n) st_q <= ST_WR;
            else           st_q <= ST_STOP;
          end
        end
        ST_RD: if (s3) begin
          if (bit_q == BW'(DW - 1)) begin
            rd_data   <= sh_q[DW-1:0];
            byte_done <= 1'b1;
            st_q      <= ST_RD_ACK;
          end else begin
            bit_q <= bit_q + BW'(1);
          end
        end
        ST_RD_ACK: begin
          if (s0) more_q <= !ce_n;
          if (s3) begin
            bit_q <= '0;
            st_q  <= more_q ? ST_RD : ST_STOP;
          end
        end
        ST_STOP: if (s3) st_q <= ST_IDLE;
        ST_ERR:  if (stop_req) st_q <= ST_STOP;
        default: st_q <= ST_IDLE;
      endcase
      scl_o    <= scl_level(st_q, phase);
      sda_oe_o <= sda_low_d;
      busy     <= (st_q != ST_IDLE);
      error    <= (st_q == ST_ERR);
    end
  end

  // SDA moves while SCL stays high only for START or STOP.
  assert_sda_moves_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
    (scl_o && $past(scl_o) && (sda_oe_o != $past(sda_oe_o)))
      |-> ($past(st_q) == ST_START || $past(st_q) == ST_STOP));

  // An idle controller leaves the bus released.
  assert_idle_bus_free_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (scl_o && !sda_oe_o && !error));

  // Idle with a high enable stays idle.
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && ce_n) |=> st_q == ST_IDLE);

  // Error parks the bus with SCL low and SDA released.
  assert_error_parks_R8: assert property (@(posedge clk) disable iff (rst)
    error |-> (!scl_o && !sda_oe_o && busy));

  // Only the stop request leaves the error state.
  assert_error_waits_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ERR && !stop_req) |=> st_q == ST_ERR);

  // Byte strobe lasts one cycle.
  assert_byte_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done);

endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  localparam int DIV_STD  = 40;
  localparam int DIV_FAST = 16;
  localparam logic [6:0] TGT = 7'h2D;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, ce_n, fast_mode, rw, stop_req;
  logic [6:0] slave_addr;
  logic [7:0] wr_data, rd_data;
  logic       scl_o, sda_oe_o, byte_done, busy, error;
  logic       slv_low;
  logic       sda_bus;
  assign sda_bus = !(sda_oe_o || slv_low);

  i2c_byte_master #(.DIV_STD(DIV_STD), .DIV_FAST(DIV_FAST), .AW(7), .DW(8)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .fast_mode(fast_mode),
    .slave_addr(slave_addr), .rw(rw), .wr_data(wr_data), .stop_req(stop_req),
    .sda_i(sda_bus), .scl_o(scl_o), .sda_oe_o(sda_oe_o), .rd_data(rd_data),
    .byte_done(byte_done), .busy(busy), .error(error)
  );

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input bit r);
    return {a, r};
  endfunction

  function automatic int ack_level(input int idx, input int n);
    return (idx == n - 1) ? 1 : 0;
  endfunction

  // Target model on the bus
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:7];
  int         macks [0:7];
  int         wcnt, ridx, mcnt, start_cnt, stop_cnt;
  int         nack_idx;
  logic [7:0] abyte;
  int         cnt;
  bit         in_addr, sel, srw, last_mack, p_scl, p_sda;
  logic [7:0] sh, rbyte;

  always @(negedge clk) begin
    bit cur;
    cur = sda_bus;
    if (rst) begin
      slv_low = 0; cnt = 0; in_addr = 0; sel = 0; srw = 0; last_mack = 1;
      start_cnt = 0; stop_cnt = 0; wcnt = 0; ridx = 0; mcnt = 0;
      sh = 0; rbyte = 0; abyte = 0;
      p_scl = 1; p_sda = 1;
    end else begin
      if (p_scl && scl_o && p_sda && !cur) begin
        start_cnt++; cnt = 0; in_addr = 1; sel = 0;
        wcnt = 0; ridx = 0; mcnt = 0;
      end else if (p_scl && scl_o && !p_sda && cur) begin
        stop_cnt++; sel = 0;
      end
      if (!p_scl && scl_o) begin
        sh = {sh[6:0], cur};
        cnt++;
        if (cnt == 8) begin
          if (in_addr) abyte = sh;
          else if (sel && !srw) begin
            if (wcnt < 8) wbuf[wcnt] = sh;
            wcnt++;
          end
        end
        if (cnt == 9 && !in_addr && sel && srw) begin
          if (mcnt < 8) macks[mcnt] = int'(cur);
          mcnt++;
          last_mack = cur;
        end
      end
      if (p_scl && !scl_o) begin
        if (cnt == 8) begin
          if (in_addr) begin
            sel = (abyte[7:1] == TGT);
            srw = abyte[0];
            slv_low = sel;
          end else if (sel && !srw) slv_low = (nack_idx != wcnt - 1);
          else slv_low = 0;
        end else if (cnt == 9) begin
          cnt = 0;
          if (sel && srw && (in_addr || !last_mack)) begin
            rbyte = rbuf[ridx & 7];
            ridx++;
            slv_low = !rbyte[7];
          end else slv_low = 0;
          in_addr = 0;
        end else if (cnt >= 1 && cnt <= 7 && !in_addr && sel && srw) begin
          slv_low = !rbyte[7 - cnt];
        end
      end
      p_scl = scl_o;
      p_sda = cur;
    end
  end

  // Bus timing monitor
  longint cyc, last_rise;
  int     pmin, pmax, hmin, hmax, bd_cnt, bd_err;
  bit     have_rise, m_scl, m_sda, m_bd;
  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; last_rise = 0; have_rise = 0; m_scl = 1; m_sda = 1; m_bd = 0;
      pmin = 1 << 30; pmax = 0; hmin = 1 << 30; hmax = 0; bd_cnt = 0; bd_err = 0;
    end else begin
      cyc++;
      if (m_scl && scl_o && m_sda && !sda_bus) begin
        have_rise = 0; pmin = 1 << 30; pmax = 0; hmin = 1 << 30; hmax = 0;
      end
      if (!m_scl && scl_o) begin
        if (have_rise) begin
          if (int'(cyc - last_rise) < pmin) pmin = int'(cyc - last_rise);
          if (int'(cyc - last_rise) > pmax) pmax = int'(cyc - last_rise);
        end
        last_rise = cyc; have_rise = 1;
      end
      if (m_scl && !scl_o && have_rise) begin
        if (int'(cyc - last_rise) < hmin) hmin = int'(cyc - last_rise);
        if (int'(cyc - last_rise) > hmax) hmax = int'(cyc - last_rise);
      end
      if (byte_done) begin
        bd_cnt++;
        if (m_bd) bd_err++;
      end
      m_scl = scl_o; m_sda = sda_bus; m_bd = byte_done;
    end
  end

  // Watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  logic [7:0] exp_w [0:7];
  int s0, p0, b0;

  task automatic run_xfer(input logic [6:0] a, input bit r, input bit f,
                          input int n, input bit poke);
    int k;
    bit seen;
    k = 0; seen = 0;
    s0 = start_cnt; p0 = stop_cnt; b0 = bd_cnt;
    @(negedge clk);
    slave_addr = a; rw = r; fast_mode = f; wr_data = exp_w[0]; ce_n = 0;
    while (!(seen && !busy)) begin
      @(negedge clk);
      stop_req = 0;
      if (busy) seen = 1;
      if (error) begin
        ce_n = 1;
        break;
      end
      if (byte_done) begin
        k++;
        if (poke && k == 1) stop_req = 1;
        if (r) chk(rd_data == rbuf[k-1], "R7", "read byte", rd_data, rbuf[k-1]);
        else wr_data = exp_w[k & 7];
        if (k == n) ce_n = 1;
      end
    end
    stop_req = 0;
  endtask

  task automatic verify(input logic [6:0] a, input bit r, input bit f, input int n);
    int div;
    div = f ? DIV_FAST : DIV_STD;
    chk(start_cnt - s0 == 1, "R3", "start count", start_cnt - s0, 1);
    chk(stop_cnt - p0 == 1, "R3", "stop count", stop_cnt - p0, 1);
    chk(abyte == addr_byte(a, r), "R5", "address byte", abyte, addr_byte(a, r));
    chk(pmin == div && pmax == div, "R4", "scl period", pmax, div);
    chk(hmin == div / 2 && hmax == div / 2, "R4", "scl high", hmin, div / 2);
    chk(bd_cnt - b0 == n && bd_err == 0, "R10", "byte strobes", bd_cnt - b0, n);
    if (!r) begin
      chk(wcnt == n, "R6", "bytes written", wcnt, n);
      for (int i = 0; i < n; i++)
        chk(wbuf[i] == exp_w[i], "R6", "write byte", wbuf[i], exp_w[i]);
    end else begin
      chk(mcnt == n, "R7", "acks seen", mcnt, n);
      for (int i = 0; i < n; i++)
        chk(macks[i] == ack_level(i, n), "R7", "master ack", macks[i], ack_level(i, n));
    end
    chk(!busy && !error && scl_o && !sda_oe_o, "R1", "idle after", {busy, error}, 0);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int n;
    bit r, f;
    void'($urandom(32'd20240611));
    rst = 1; ce_n = 1; fast_mode = 0; rw = 0; stop_req = 0;
    slave_addr = TGT; wr_data = 0; nack_idx = -1;
    for (int i = 0; i < 8; i++) begin exp_w[i] = 0; rbuf[i] = 0; end
    wait_cycles(5);
    rst = 0;
    @(negedge clk);
    chk(scl_o && !sda_oe_o && !busy && !error, "R1", "reset state",
        {scl_o, sda_oe_o, busy, error}, 4'b1000);

    // R2: enable high keeps it idle
    s0 = start_cnt;
    wait_cycles(300);
    chk(!busy && scl_o && start_cnt == s0, "R2", "idle with ce_n high", busy, 0);

    // R11: stop request in idle
    p0 = stop_cnt;
    stop_req = 1; @(negedge clk); stop_req = 0;
    wait_cycles(100);
    chk(!busy && scl_o && stop_cnt == p0, "R11", "stop_req idle", stop_cnt - p0, 0);

    // Directed write, fast, three bytes, edge patterns
    exp_w[0] = 8'hFF; exp_w[1] = 8'h00; exp_w[2] = 8'hA5;
    run_xfer(TGT, 0, 1, 3, 0);
    verify(TGT, 0, 1, 3);

    // Directed read, standard, two bytes
    rbuf[0] = 8'h81; rbuf[1] = 8'h7E;
    run_xfer(TGT, 1, 0, 2, 0);
    verify(TGT, 1, 0, 2);

    // R11: stop request during a healthy write
    exp_w[0] = 8'h3C; exp_w[1] = 8'hC3;
    run_xfer(TGT, 0, 0, 2, 1);
    verify(TGT, 0, 0, 2);

    // Random transfers
    for (int t = 0; t < 12; t++) begin
      r = 1'($urandom % 2);
      f = 1'($urandom % 2);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < 8; i++) begin
        exp_w[i] = 8'($urandom);
        rbuf[i]  = 8'($urandom);
      end
      run_xfer(TGT, r, f, n, 0);
      verify(TGT, r, f, n);
    end

    // R8/R9: address not acknowledged
    p0 = stop_cnt;
    run_xfer(7'h13, 0, 1, 1, 0);
    wait_cycles(3 * DIV_STD);
    chk(error && busy, "R8", "address nack error", {error, busy}, 2'b11);
    chk(!scl_o && !sda_oe_o, "R8", "parked bus", {scl_o, sda_oe_o}, 0);
    chk(stop_cnt == p0, "R8", "no stop while parked", stop_cnt - p0, 0);
    stop_req = 1; @(negedge clk); stop_req = 0;
    while (busy) @(negedge clk);
    chk(stop_cnt - p0 == 1, "R9", "stop after request", stop_cnt - p0, 1);
    chk(!error && !busy && scl_o, "R9", "idle after recovery", {error, busy}, 0);

    // R8/R9: second written byte refused
    exp_w[0] = 8'h11; exp_w[1] = 8'h22; exp_w[2] = 8'h33;
    nack_idx = 1;
    p0 = stop_cnt;
    run_xfer(TGT, 0, 0, 3, 0);
    wait_cycles(2 * DIV_STD);
    chk(error && busy && !scl_o, "R8", "data nack error", {error, busy, scl_o}, 3'b110);
    chk(wcnt == 2 && bd_cnt - b0 == 2, "R8", "bytes before abort", wcnt, 2);
    chk(stop_cnt == p0, "R8", "no stop on data nack", stop_cnt - p0, 0);
    stop_req = 1; @(negedge clk); stop_req = 0;
    while (busy) @(negedge clk);
    chk(stop_cnt - p0 == 1 && !error, "R9", "stop after data nack", stop_cnt - p0, 1);
    nack_idx = -1;

    // R9: new transfer after recovery
    rbuf[0] = 8'h5A;
    run_xfer(TGT, 1, 1, 1, 0);
    verify(TGT, 1, 1, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule